// File: doc/BRIEF.md
# Dual Mains Rejection Filter

This block is a streaming FIR filter for a digitized sensor channel. It removes power-line hum at 50 Hz and at 60 Hz together. Each accepted input sample produces exactly one output sample, so the output rate equals the input rate. The default configuration assumes a fixed input rate of 6000 samples per second.

In mains mode the filter is a chain of running-sum stages. Three stages each span 120 samples, which is one 50 Hz period. They feed a fourth stage that spans 100 samples, which is one 60 Hz period. The 50 Hz part is a third-order section with a Gaussian-like impulse response, and the last stage adds a null at 60 Hz. In notch mode a single 600-sample running sum gives a plain rectangular average over 100 ms, which puts its first null at 10 Hz.

In both modes the final sum is scaled by a fixed-point reciprocal of the total tap weight, so the gain at DC is exactly one. The result is rounded to nearest and saturated to the output width. A settled flag shows when the output no longer depends on the zero history that exists after reset or after a mode change. Output samples are marked valid only once that flag is high.

Top module: `rej_top`

## Requirements
- R1: During and directly after a synchronous reset, `out_valid`, `settled` and `out_data` are all 0, and mains mode is active.
- R2: With `mode` = 0 (mains), output sample n equals the input convolved with three 120-sample unit boxcars and one 100-sample unit boxcar, divided by 120*120*120*100 and rounded to nearest, within one LSB.
- R3: A constant input produces that same constant at the output within one LSB once settled, including both full-scale extremes +32767 and -32768.
- R4: In mains mode, any sum of a tone with a period of 120 samples (50 Hz) and a tone with a period of 100 samples (60 Hz) gives outputs of magnitude at most one LSB once settled.
- R5: With `mode` = 1 (notch), output sample n equals the rounded mean of the last 600 inputs, within one LSB. A tone with a period of 600 samples (10 Hz) gives outputs of magnitude at most one LSB.
- R6: `settled` rises together with the output of the 457th accepted sample in mains mode, or the 600th in notch mode, counted since reset or since the last mode change. It then stays high until the next reset or mode change. `out_valid` is never high while `settled` is low.
- R7: An accepted sample produces its output `out_valid` pulse 5 clock edges after the edge that accepts it in mains mode, and 2 edges after in notch mode. The accepting edge is counted as the first.
- R8: A change of `mode` clears all filter state. On the next cycle `settled` and `out_valid` are low. A sample presented in the cycle of the change is discarded. Later outputs depend only on samples accepted after the change.
- R9: Cycles with `in_valid` low leave the filter unchanged. Once settled, every accepted sample yields exactly one output pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = mains rejection, 1 = 10 Hz notch; a change clears the filter |
| in_valid | input | 1 | Qualifies `in_data` for one cycle |
| in_data | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| out_data | output | 16 | Signed filtered sample, rounded and saturated |
| settled | output | 1 | High once the delay lines hold only real samples |

## Verification
Stage state is kept as running sums, so a single wrong add, subtract or pointer wrap does not fade away. It leaves a permanent offset or ripple in `out_data` from the first settled output onward. Comparing every valid output against an independently built impulse response exposes such a fault within one window length. A wrong fill count or clear shows up at once as `settled` rising too early or too late relative to the accepted sample count. Wrong pipeline depth appears as an `out_valid` pulse at the wrong edge after a single isolated sample.

// File: rtl/rej_pkg.sv
package rej_pkg;

    typedef enum logic {
        MODE_MAINS = 1'b0,
        MODE_NOTCH = 1'b1
    } rej_mode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rej_boxcar.sv
// Running-sum stage over the last LEN accepted samples.
// While the delay line is still filling, the departing sample is taken as zero,
// so the stage behaves as if preloaded with zeros without clearing the memory.
module rej_boxcar #(
    parameter int LEN = 120,
    parameter int IW  = 16,
    parameter int OW  = IW + $clog2(LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 in_vld,
    input  logic signed [IW-1:0] in_dat,
    output logic                 out_vld,
    output logic signed [OW-1:0] out_sum
);
    localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic [PW-1:0]        ptr;
        logic                 full;
        logic signed [OW-1:0] sum;
        logic                 vld;
    } box_state_t;

    box_state_t q, d;
    logic signed [IW-1:0] line_q [LEN];
    logic signed [IW-1:0] leaving;

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        leaving = q.full ? line_q[q.ptr] : '0;
        if (clr) begin
            d = '0;
        end else if (in_vld) begin
            d.sum = q.sum + OW'(in_dat) - OW'(leaving);
            d.vld = 1'b1;
            if (q.ptr == PW'(LEN - 1)) begin
                d.ptr  = '0;
                d.full = 1'b1;
            end else begin
                d.ptr = q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_ff @(posedge clk) begin
        if (in_vld && !clr) line_q[q.ptr] <= in_dat;
    end

    assign out_vld = q.vld;
    assign out_sum = q.sum;

endmodule

// File: rtl/rej_scale.sv
// Multiplies a window sum by a fixed-point reciprocal of the tap weight,
// rounds to nearest and saturates to the output width.
module rej_scale #(
    parameter int              SW      = 44,
    parameter int              OUT_W   = 16,
    parameter int              SHIFT   = 48,
    parameter int              RW      = 40,
    parameter longint unsigned RECIP_A = 64'd1,
    parameter longint unsigned RECIP_B = 64'd1
) (
    input  logic                    sel,
    input  logic signed [SW-1:0]    sum,
    output logic signed [OUT_W-1:0] res
);
    localparam int PW = SW + RW + 1;
    localparam logic [RW-1:0] RA = RW'(RECIP_A);
    localparam logic [RW-1:0] RB = RW'(RECIP_B);
    localparam longint MAXL = (longint'(1) <<< (OUT_W - 1)) - 1;
    localparam longint MINL = -MAXL - 1;
    localparam logic signed [PW-1:0] HALF = PW'(longint'(1)) <<< (SHIFT - 1);
    localparam logic signed [PW-1:0] MAXV = PW'(MAXL);
    localparam logic signed [PW-1:0] MINV = PW'(MINL);

    logic [RW-1:0]        recip;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;

    always_comb begin
        recip = sel ? RB : RA;
        prod  = PW'(sum) * PW'($signed({1'b0, recip}));
        quot  = (prod + HALF) >>> SHIFT;
        if (quot > MAXV)      res = MAXV[OUT_W-1:0];
        else if (quot < MINV) res = MINV[OUT_W-1:0];
        else                  res = quot[OUT_W-1:0];
    end

endmodule

// File: rtl/rej_top.sv
module rej_top
    import rej_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    parameter int L50   = 120,
    parameter int N50   = 3,
    parameter int L60   = 100,
    parameter int L10   = 600,
    parameter int SHIFT = 48
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    settled
);
    localparam int B50 = $clog2(L50);
    localparam int B60 = $clog2(L60);
    localparam int W50 = IN_W + N50 * B50;
    localparam int W60 = W50 + B60;
    localparam int WNT = IN_W + $clog2(L10);
    localparam int WF  = imax(W60, WNT);

    localparam longint unsigned WT_M  = 64'(L50) ** N50 * 64'(L60);
    localparam longint unsigned WT_N  = 64'(L10);
    localparam longint unsigned ONE_S = 64'd1 << SHIFT;
    localparam longint unsigned RC_M  = (ONE_S + WT_M / 2) / WT_M;
    localparam longint unsigned RC_N  = (ONE_S + WT_N / 2) / WT_N;
    localparam longint unsigned RC_X  = (RC_M > RC_N) ? RC_M : RC_N;
    localparam int RW = $clog2(RC_X + 1);

    localparam int IR_M = N50 * (L50 - 1) + L60;
    localparam int IR_N = L10;
    localparam int CW   = $clog2(imax(IR_M, IR_N) + 1);

    typedef struct packed {
        rej_mode_e               mode;
        logic [CW-1:0]           cnt;
        logic                    settled;
        logic                    ovld;
        logic signed [OUT_W-1:0] odat;
    } top_state_t;

    top_state_t q, d;
    rej_mode_e  mode_in;
    logic       clr;
    logic       notch_act;
    logic       vld_m, vld_n;

    assign mode_in   = rej_mode_e'(mode);
    assign clr       = (mode_in != q.mode);
    assign notch_act = (q.mode == MODE_NOTCH);
    assign vld_m     = in_valid && !clr && !notch_act;
    assign vld_n     = in_valid && !clr && notch_act;

    // third-order 50 Hz section
    for (genvar i = 0; i < N50; i++) begin : g50
        localparam int IWI = IN_W + i * B50;
        localparam int OWI = IWI + B50;
        logic signed [IWI-1:0] din;
        logic                  dv;
        logic signed [OWI-1:0] sum;
        logic                  sv;
        if (i == 0) begin : g_head
            assign din = in_data;
            assign dv  = vld_m;
        end else begin : g_link
            assign din = g50[i-1].sum;
            assign dv  = g50[i-1].sv;
        end
        rej_boxcar #(.LEN(L50), .IW(IWI), .OW(OWI)) u_box (
            .clk(clk), .rst(rst), .clr(clr),
            .in_vld(dv), .in_dat(din),
            .out_vld(sv), .out_sum(sum)
        );
    end

    // first-order 60 Hz section
    logic signed [W60-1:0] s60;
    logic                  v60;
    rej_boxcar #(.LEN(L60), .IW(W50), .OW(W60)) u_box60 (
        .clk(clk), .rst(rst), .clr(clr),
        .in_vld(g50[N50-1].sv), .in_dat(g50[N50-1].sum),
        .out_vld(v60), .out_sum(s60)
    );

    // single long average for the 10 Hz notch
    logic signed [WNT-1:0] snt;
    logic                  vnt;
    rej_boxcar #(.LEN(L10), .IW(IN_W), .OW(WNT)) u_box10 (
        .clk(clk), .rst(rst), .clr(clr),
        .in_vld(vld_n), .in_dat(in_data),
        .out_vld(vnt), .out_sum(snt)
    );

    logic                    fin_vld;
    logic signed [WF-1:0]    fin_sum;
    logic signed [OUT_W-1:0] scaled;
    logic [CW-1:0]           last_idx;

    assign fin_vld  = notch_act ? vnt : v60;
    assign fin_sum  = notch_act ? WF'(snt) : WF'(s60);
    assign last_idx = notch_act ? CW'(IR_N - 1) : CW'(IR_M - 1);

    rej_scale #(
        .SW(WF), .OUT_W(OUT_W), .SHIFT(SHIFT), .RW(RW),
        .RECIP_A(RC_M), .RECIP_B(RC_N)
    ) u_scale (
        .sel(notch_act), .sum(fin_sum), .res(scaled)
    );

    always_comb begin
        d      = q;
        d.ovld = 1'b0;
        if (clr) begin
            d      = '0;
            d.mode = mode_in;
        end else if (fin_vld) begin
            if (!q.settled) begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == last_idx) d.settled = 1'b1;
            end
            d.ovld = q.settled || (q.cnt == last_idx);
            d.odat = scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign out_valid = q.ovld;
    assign out_data  = q.odat;
    assign settled   = q.settled;

endmodule

// File: rtl/rej_top_chk.sv
module rej_top_chk (
    input logic clk,
    input logic rst,
    input logic clr,
    input logic notch_act,
    input logic in_valid,
    input logic out_valid,
    input logic settled
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!settled && !out_valid));

    assert_valid_needs_settled_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> settled);

    assert_settled_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (settled && !clr) |=> settled);

    assert_rise_with_output_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> out_valid);

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!settled && !out_valid));

    assert_mains_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !notch_act) |-> $past(in_valid, 5));

    assert_notch_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && notch_act) |-> $past(in_valid, 2));

endmodule

bind rej_top rej_top_chk u_chk (
    .clk(clk), .rst(rst), .clr(clr), .notch_act(notch_act),
    .in_valid(in_valid), .out_valid(out_valid), .settled(settled)
);

// File: tb/sim_rej_top.sv
`timescale 1ns/1ps
module sim_rej_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               mode = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic signed [15:0] out_data;
    logic               settled;

    rej_top u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .settled(settled)
    );

    always #2.5 clk = ~clk;

    int     n_tests = 0;
    int     n_fail  = 0;
    int     hist [0:4095];
    int     h    [0:599];
    int     tmp  [0:599];
    int     hlen;
    longint wsum;
    int     ncnt, ocnt, maxabs, last_out;
    bit     cur_notch;
    bit     mon_en = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_box(input int len);
        for (int n = 0; n < hlen + len - 1; n++) begin
            tmp[n] = 0;
            for (int j = 0; j < len; j++)
                if (n - j >= 0 && n - j < hlen) tmp[n] += h[n - j];
        end
        hlen = hlen + len - 1;
        for (int n = 0; n < hlen; n++) h[n] = tmp[n];
    endtask

    task automatic build_h(input bit notch);
        cur_notch = notch;
        hlen = 1;
        h[0] = 1;
        if (notch) add_box(600);
        else begin
            add_box(120); add_box(120); add_box(120); add_box(100);
        end
        wsum = 0;
        for (int k = 0; k < hlen; k++) wsum += h[k];
    endtask

    function automatic int expect_at(input int n);
        longint s = 0;
        real    r;
        int     e;
        for (int k = 0; k < hlen; k++)
            if (n - k >= 0) s += longint'(h[k]) * hist[n - k];
        r = real'(s) / real'(wsum);
        e = $rtoi($floor(r + 0.5));
        if (e > 32767) e = 32767;
        if (e < -32768) e = -32768;
        return e;
    endfunction

    function automatic int rsym(input real x);
        if (x >= 0.0) return $rtoi($floor(x + 0.5));
        return -$rtoi($floor(-x + 0.5));
    endfunction

    // output monitor: every valid output against the convolution model (R2 / R5)
    always @(negedge clk) begin
        int e, a;
        if (mon_en && !rst && out_valid) begin
            e = expect_at(ocnt + hlen - 1);
            a = int'(out_data);
            if (cur_notch) check((a - e) <= 1 && (e - a) <= 1, "R5 notch sample", a, e);
            else           check((a - e) <= 1 && (e - a) <= 1, "R2 mains sample", a, e);
            if (a > maxabs) maxabs = a;
            if (-a > maxabs) maxabs = -a;
            last_out = a;
            ocnt++;
        end
    end

    task automatic send(input int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(v);
        hist[ncnt] = v;
        ncnt++;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; mode = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && !settled && out_data == 0, "R1 state in reset", {out_valid, settled}, 0);
        rst = 1'b0;
        ncnt = 0; ocnt = 0; maxabs = 0;
        build_h(1'b0);
        @(negedge clk);
        check(!out_valid && !settled && out_data == 0, "R1 state after reset", {out_valid, settled}, 0);
    endtask

    task automatic switch_mode(input bit m);
        idle(10);
        @(negedge clk);
        mode = m;
        in_valid = 1'b1;
        in_data  = 16'sd30000;  // presented in the change cycle: must be dropped (R8)
        @(negedge clk);
        in_valid = 1'b0;
        check(!settled && !out_valid, "R8 cleared after mode change", {settled, out_valid}, 0);
        ncnt = 0; ocnt = 0; maxabs = 0;
        build_h(m);
    endtask

    task automatic t_const(input int v, input string tag);
        int n0;
        n0 = ncnt;
        repeat (hlen + 40) send(v);
        idle(10);
        check(ocnt == ncnt - hlen + 1, "R9 one output per sample", ocnt, ncnt - hlen + 1);
        check((last_out - v) <= 1 && (v - last_out) <= 1, tag, last_out, v);
        if (n0 == 0) check(ocnt == 41, "R6 settled after window", ocnt, 41);
    endtask

    task automatic t_latency(input bit notch, input int exp_edges);
        int first, pulses;
        if (notch) switch_mode(1'b1); else do_reset();
        for (int i = 0; i < hlen - 1; i++) send(i * 7 - 900);
        idle(12);
        check(!settled && ocnt == 0, "R6 not settled one sample short", settled, 0);
        send(555);
        first = -1; pulses = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid) begin
                pulses++;
                if (first < 0) first = k;
            end
        end
        check(first == exp_edges, "R7 output edge count", first, exp_edges);
        check(pulses == 1, "R9 single pulse per sample", pulses, 1);
        check(settled, "R6 settled on final window sample", settled, 1);
    endtask

    task automatic t_mains_tones();
        do_reset();
        for (int i = 0; i < 900; i++)
            send(rsym(15000.0 * $sin(6.283185307179586 * i / 120.0))
               + rsym(14000.0 * $sin(6.283185307179586 * i / 100.0 + 0.7)));
        idle(10);
        check(ocnt == 900 - hlen + 1, "R4 output count", ocnt, 900 - hlen + 1);
        check(maxabs <= 1, "R4 50/60 Hz residue", maxabs, 1);
    endtask

    task automatic t_notch_tone();
        for (int i = 0; i < 900; i++)
            send(rsym(25000.0 * $sin(6.283185307179586 * i / 600.0 + 0.3)));
        idle(10);
        check(ocnt == 900 - hlen + 1, "R5 output count", ocnt, 900 - hlen + 1);
        check(maxabs <= 1, "R5 10 Hz residue", maxabs, 1);
    endtask

    task automatic t_random_gaps(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            send(int'($urandom_range(0, 65535)) - 32768);
            if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(10);
        check(ocnt == ncnt - hlen + 1, tag, ocnt, ncnt - hlen + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        build_h(1'b0);
        ncnt = 0; ocnt = 0; maxabs = 0; last_out = 0;
        mon_en = 1'b1;
        do_reset();
        t_const(12345, "R3 mains constant");
        do_reset();
        t_const(32767, "R3 positive full scale");
        do_reset();
        t_const(-32768, "R3 negative full scale");
        t_latency(1'b0, 5);
        t_mains_tones();
        do_reset();
        t_random_gaps(1100, "R9 mains gaps count");
        switch_mode(1'b1);
        t_notch_tone();
        t_const(-1234, "R3 notch constant");
        t_random_gaps(900, "R9 notch gaps count");
        switch_mode(1'b0);
        t_random_gaps(700, "R8 fresh history after change");
        t_latency(1'b1, 2);
        idle(5);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule